// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block connects a simple synchronous request port to an asynchronous DRAM of 512K bytes. The DRAM takes its address in two halves over one 10-bit bus: first the row half, then the column half. The controller drives the row strobe, the column strobe, the write enable, the output enable and the multiplexed address. It also drives the write byte onto the data bus, together with a drive-enable for the bus pads, and it samples the byte that the DRAM returns. Every timing interval is a parameter counted in clock cycles.

After an access the row stays open. A later request to the same row needs only a new column strobe, with no new row cycle. A request to a different row closes the page first: the row strobe rises and the precharge time passes. A limit on how long the row strobe may stay low also closes the page, even when more hits are waiting. Writes always use early-write ordering, so the write enable falls before the column strobe. A free-running interval timer raises a refresh request. The controller then closes any open page once the column access in progress has finished, and it performs a refresh with the column strobe lowered before the row strobe. Refresh has priority over host requests.

The request port follows valid/ready rules. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. While `req_valid` is high and `req_ready` is low, the requester must hold the address, the write flag and the data. `req_ready` may depend on `req_addr`, because a row hit is judged from it. Read data returns in request order as a one-cycle `rd_valid` pulse, and it cannot be back-pressured.

Top module: `fpm_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, `dram_ras_n`, `dram_cas_n`, `dram_we_n` and `dram_oe_n` are 1, and `dram_dq_drive` and `rd_valid` are 0. In that first idle cycle `req_ready` is 1.
- R2: Address bits [18:9] are the row and bits [8:0] are the column. The row appears on `dram_a` in the cycle the row strobe falls. The column, zero-extended, appears in the cycle the column strobe falls.
- R3: A read returns the byte last written to its address (0 if never written) as a one-cycle `rd_valid` pulse, in request order. The controller samples that byte no sooner than 70 ns after the row strobe fell, 20 ns after the column strobe fell and 35 ns after the column address was presented.
- R4: For a write, `dram_we_n` is low in the cycle before the column strobe falls and stays low through the column pulse, and `dram_dq_drive` is 1 whenever `dram_we_n` is low. `dram_oe_n` is low only during a read column pulse, and never in a cycle where `dram_dq_drive` is 1.
- R5: A request whose row matches the open page is served by a column strobe alone, with no new row strobe. Between column pulses the column strobe stays high for at least T_CP+1 cycles.
- R6: A request to another row raises the row strobe. The row strobe then stays high at least T_RP cycles, and two row strobe falls are at least 130 ns apart.
- R7: The row strobe never stays low for more than T_RAS_MAX consecutive cycles. A long run of page hits is split across several row cycles.
- R8: Each refresh lowers the column strobe at least one cycle before the row strobe, with `dram_we_n` high. Successive refreshes, and the first refresh after reset, are at most T_REF + T_RAS_MAX + T_RP + T_RC + 4 cycles apart. A long idle time brings repeated refreshes.
- R9: While a refresh is pending, `req_ready` is 0. A continuous stream of page hits does not delay refresh beyond the bound given in R8.
- R10: The controller starts no host row or column cycle unless a request was accepted. Every accepted read produces exactly one `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address, row in [18:9], column in [8:0] |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte valid, one cycle |
| rd_data | output | 8 | Read byte |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_a | output | 10 | Multiplexed row/column address |
| dram_dq_out | output | 8 | Byte driven to the DRAM |
| dram_dq_drive | output | 1 | Drive enable for the data pads |
| dram_dq_in | input | 8 | Byte returned by the DRAM |

## Verification
A wrong stored open-row value shows up on the first following hit. Either a needless row cycle appears, or a column strobe lands in the wrong row and the read returns another byte a few cycles later. A countdown that is off by one shows in the very access it belongs to. The DRAM model in the bench returns corrupted data if sampling comes before any of the three access times, and it flags a precharge or row-cycle violation at the next row strobe fall. A lost refresh request or a stuck page guard cannot be seen quickly. It shows only as a refresh gap that grows past the bound, or as a row strobe low time that grows past its limit, within one refresh interval.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,   // row strobe high, page closed
    ST_ROW,    // row strobe falls, row address on the bus
    ST_RCD,    // column address on the bus, waiting for RAS-to-CAS delay
    ST_CADR,   // page hit: new column address set up
    ST_COL,    // column strobe low
    ST_OPEN,   // page open, column strobe high
    ST_PRE,    // row precharge
    ST_REFC,   // refresh: column strobe low ahead of row strobe
    ST_REFR    // refresh: both strobes low
  } fpm_state_e;
endpackage

// File: rtl/fpm_refresh_timer.sv
module fpm_refresh_timer #(
  parameter int PERIOD = 1560
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int W = $clog2(PERIOD + 1);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= W'(PERIOD - 1);
      tick <= 1'b0;
    end else begin
      tick <= (cnt == '0);
      cnt  <= (cnt == '0) ? W'(PERIOD - 1) : cnt - 1'b1;
    end
  end
endmodule

// File: rtl/fpm_page_guard.sv
module fpm_page_guard #(
  parameter int ROW_W   = 10,
  parameter int RAS_MAX = 40,
  parameter int LIMIT   = 33
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_low,
  input  logic             load,
  input  logic [ROW_W-1:0] row_in,
  input  logic [ROW_W-1:0] req_row,
  output logic [ROW_W-1:0] open_row,
  output logic             hit,
  output logic             expired
);
  localparam int W = $clog2(RAS_MAX + 2);
  logic [W-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_cnt  <= '0;
      open_row <= '0;
    end else begin
      if (!ras_low)                     low_cnt <= '0;
      else if (low_cnt != W'(RAS_MAX))  low_cnt <= low_cnt + 1'b1;
      if (load) open_row <= row_in;
    end
  end

  assign hit     = (req_row == open_row);
  assign expired = (low_cnt >= W'(LIMIT));
endmodule

// File: rtl/fpm_ctrl.sv
module fpm_ctrl
  import fpm_pkg::*;
#(
  parameter int ROW_W     = 10,
  parameter int COL_W     = 9,
  parameter int DQ_W      = 8,
  parameter int T_RCD     = 3,
  parameter int T_CAS     = 4,
  parameter int T_CP      = 2,
  parameter int T_RP      = 5,
  parameter int T_RC      = 13,
  parameter int T_RAS_MAX = 40,
  parameter int T_REF     = 1560
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DQ_W-1:0]        req_wdata,
  output logic                   rd_valid,
  output logic [DQ_W-1:0]        rd_data,
  output logic                   dram_ras_n,
  output logic                   dram_cas_n,
  output logic                   dram_we_n,
  output logic                   dram_oe_n,
  output logic [ROW_W-1:0]       dram_a,
  output logic [DQ_W-1:0]        dram_dq_out,
  output logic                   dram_dq_drive,
  input  logic [DQ_W-1:0]        dram_dq_in
);
  localparam int T_REFR     = T_RCD + T_CAS;
  localparam int PAGE_LIMIT = T_RAS_MAX - T_CAS - T_CP - 1;
  localparam int CNT_W      = $clog2(T_REFR + T_RP + T_CP + T_RCD + 2);
  localparam int RC_W       = $clog2(T_RC + 1);

  fpm_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic [RC_W-1:0]  rc_cnt;
  logic [COL_W-1:0] col_q;
  logic             wr_q;
  logic [DQ_W-1:0]  wd_q;
  logic             ref_pend;
  logic             tick, hit, expired, ras_low, accept, rc_ok, cnt_done;
  logic [ROW_W-1:0] open_row;
  logic [ROW_W-1:0] req_row;
  logic [COL_W-1:0] req_col;

  assign req_row  = req_addr[ROW_W+COL_W-1:COL_W];
  assign req_col  = req_addr[COL_W-1:0];
  assign rc_ok    = (rc_cnt == '0);
  assign cnt_done = (cnt == '0);
  assign ras_low  = state inside {ST_ROW, ST_RCD, ST_CADR, ST_COL, ST_OPEN, ST_REFR};

  assign req_ready = !ref_pend &&
                     ((state == ST_IDLE && rc_ok) ||
                      (state == ST_OPEN && cnt_done && !expired && hit));
  assign accept    = req_valid && req_ready;

  fpm_refresh_timer #(.PERIOD(T_REF)) u_ref (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  fpm_page_guard #(.ROW_W(ROW_W), .RAS_MAX(T_RAS_MAX), .LIMIT(PAGE_LIMIT)) u_page (
    .clk(clk), .rst_n(rst_n), .ras_low(ras_low),
    .load(state == ST_IDLE && accept), .row_in(req_row), .req_row(req_row),
    .open_row(open_row), .hit(hit), .expired(expired)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      rc_cnt   <= '0;
      col_q    <= '0;
      wr_q     <= 1'b0;
      wd_q     <= '0;
      ref_pend <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (!rc_ok) rc_cnt <= rc_cnt - 1'b1;
      case (state)
        ST_IDLE: begin
          if (ref_pend && rc_ok) begin
            state    <= ST_REFC;
            ref_pend <= 1'b0;
          end else if (accept) begin
            state  <= ST_ROW;
            col_q  <= req_col;
            wr_q   <= req_write;
            wd_q   <= req_wdata;
            rc_cnt <= RC_W'(T_RC - 1);
          end
        end
        ST_ROW: begin
          state <= ST_RCD;
          cnt   <= CNT_W'(T_RCD - 2);
        end
        ST_RCD: begin
          if (cnt_done) begin
            state <= ST_COL;
            cnt   <= CNT_W'(T_CAS - 1);
          end else cnt <= cnt - 1'b1;
        end
        ST_CADR: begin
          state <= ST_COL;
          cnt   <= CNT_W'(T_CAS - 1);
        end
        ST_COL: begin
          if (cnt_done) begin
            state <= ST_OPEN;
            cnt   <= CNT_W'(T_CP - 1);
            if (!wr_q) begin
              rd_valid <= 1'b1;
              rd_data  <= dram_dq_in;
            end
          end else cnt <= cnt - 1'b1;
        end
        ST_OPEN: begin
          if (!cnt_done) cnt <= cnt - 1'b1;
          else if (ref_pend || expired || (req_valid && !hit)) begin
            state <= ST_PRE;
            cnt   <= CNT_W'(T_RP - 1);
          end else if (accept) begin
            state <= ST_CADR;
            col_q <= req_col;
            wr_q  <= req_write;
            wd_q  <= req_wdata;
          end
        end
        ST_PRE: begin
          if (cnt_done) state <= ST_IDLE;
          else cnt <= cnt - 1'b1;
        end
        ST_REFC: begin
          state  <= ST_REFR;
          cnt    <= CNT_W'(T_REFR - 1);
          rc_cnt <= RC_W'(T_RC - 1);
          wr_q   <= 1'b0;
        end
        ST_REFR: begin
          if (cnt_done) begin
            state <= ST_PRE;
            cnt   <= CNT_W'(T_RP - 1);
          end else cnt <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
      if (tick) ref_pend <= 1'b1;
    end
  end

  assign dram_ras_n    = !ras_low;
  assign dram_cas_n    = !(state inside {ST_COL, ST_REFC, ST_REFR});
  assign dram_dq_drive = wr_q && (state inside {ST_RCD, ST_CADR, ST_COL});
  assign dram_we_n     = !dram_dq_drive;
  assign dram_oe_n     = !(!wr_q && state == ST_COL);
  assign dram_dq_out   = wd_q;
  assign dram_a        = (state == ST_ROW) ? open_row : ROW_W'(col_q);
endmodule

// File: rtl/fpm_ctrl_chk.sv
module fpm_ctrl_chk #(
  parameter int T_RAS_MAX = 40,
  parameter int T_RP      = 5
) (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic oe_n,
  input logic dq_drive,
  input logic rd_valid,
  input logic req_ready,
  input logic ref_pend
);
  localparam int W = $clog2(T_RAS_MAX + T_RP + 2);
  logic [W-1:0] lo_cnt, hi_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_cnt <= '0;
      hi_cnt <= W'(T_RP);
    end else begin
      if (ras_n) lo_cnt <= '0;
      else if (lo_cnt != W'(T_RAS_MAX + 1)) lo_cnt <= lo_cnt + 1'b1;
      if (!ras_n) hi_cnt <= '0;
      else if (hi_cnt < W'(T_RP)) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  // R4: pads never driven while the DRAM output buffer is enabled
  p_drive_no_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(dq_drive && !oe_n));

  // R4: early write, the write enable is already low before the column strobe falls
  p_we_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !ras_n && !we_n) |-> $past(!we_n));

  // R8: column strobe before row strobe, no write during refresh
  p_cbr_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> ($past(!cas_n) && we_n));

  // R7: row strobe low time bounded
  p_ras_max_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> (lo_cnt < W'(T_RAS_MAX)));

  // R6: precharge satisfied at each row strobe fall
  p_precharge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (hi_cnt >= W'(T_RP)));

  // R9: no host request accepted while refresh is pending
  p_ref_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pend |-> !req_ready);

  // R3: read data valid is a single-cycle pulse
  p_rdv_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
endmodule

bind fpm_ctrl fpm_ctrl_chk #(.T_RAS_MAX(T_RAS_MAX), .T_RP(T_RP)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n), .cas_n(dram_cas_n),
  .we_n(dram_we_n), .oe_n(dram_oe_n), .dq_drive(dram_dq_drive),
  .rd_valid(rd_valid), .req_ready(req_ready), .ref_pend(ref_pend)
);

// File: tb/tb_fpm_ctrl.sv
module tb_fpm_ctrl;
  localparam int CLK_NS    = 10;
  localparam int T_RCD     = 3;
  localparam int T_CAS     = 4;
  localparam int T_CP      = 2;
  localparam int T_RP      = 5;
  localparam int T_RAS_MAX = 40;
  localparam int T_REF     = 1560;
  localparam int RAC_NS = 70, CAC_NS = 20, AA_NS = 35, RC_NS = 130;
  localparam int RC_CYC    = (RC_NS + CLK_NS - 1) / CLK_NS;
  localparam int REF_SLACK = T_RAS_MAX + T_RP + 13 + 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0] req_wdata = '0, dram_dq_in = '0;
  logic req_ready, rd_valid, dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_drive;
  logic [7:0] rd_data, dram_dq_out;
  logic [9:0] dram_a;

  always #(CLK_NS/2) clk = ~clk;

  fpm_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
    .dram_a(dram_a), .dram_dq_out(dram_dq_out), .dram_dq_drive(dram_dq_drive),
    .dram_dq_in(dram_dq_in)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  int n_open = 0, n_ref = 0, n_rdv = 0, n_rd_issued = 0;
  logic [7:0] mem [int];
  logic [7:0] shadow [int];
  logic [7:0] exp_q [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_rd(input int k);
    return mem.exists(k) ? mem[k] : 8'h00;
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // Behavioural DRAM model and per-clock protocol comparison
  logic pr_ras = 1'b1, pr_cas = 1'b1, pr_we = 1'b1;
  logic [9:0] pr_a = '0;
  int ras_t = 0, cas_t = 0, a_t = 0, lo_run = 0, hi_run = 100, cas_hi = 100;
  int last_fall = -1000, last_ref = 0, m_row = 0, m_col = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (pr_ras && !dram_ras_n) begin
        chk(cyc - last_fall >= RC_CYC, "R6", "row cycle time", cyc - last_fall, RC_CYC);
        chk(hi_run >= T_RP, "R6", "row precharge", hi_run, T_RP);
        last_fall = cyc;
        if (!dram_cas_n) begin
          n_ref++;
          chk(dram_we_n && !pr_cas, "R8", "refresh order", int'(dram_we_n), 1);
          chk(cyc - last_ref <= T_REF + REF_SLACK, "R8", "refresh gap", cyc - last_ref, T_REF + REF_SLACK);
          last_ref = cyc;
        end else begin
          n_open++;
          m_row = int'(dram_a);
        end
        ras_t = 0;
      end else ras_t++;
      if (pr_cas && !dram_cas_n && !dram_ras_n) begin
        chk(cas_hi >= T_CP + 1, "R5", "column precharge", cas_hi, T_CP + 1);
        m_col = int'(dram_a[8:0]);
        chk(dram_a[9] == 1'b0, "R2", "column msb", int'(dram_a[9]), 0);
        if (!dram_we_n) begin
          chk(!pr_we && dram_dq_drive && dram_oe_n, "R4", "early write setup", int'(pr_we), 0);
          mem[m_row * 512 + m_col] = dram_dq_out;
        end
        cas_t = 0;
      end else cas_t++;
      if (dram_a != pr_a) a_t = 0; else a_t++;
      if (!dram_ras_n) begin
        lo_run++;
        chk(lo_run <= T_RAS_MAX, "R7", "row strobe low time", lo_run, T_RAS_MAX);
        hi_run = 0;
      end else begin
        lo_run = 0;
        hi_run++;
      end
      if (dram_cas_n) cas_hi++; else cas_hi = 0;
      chk(!(dram_dq_drive && !dram_oe_n), "R4", "drive with output enable", int'(dram_dq_drive), 0);
      if (!dram_ras_n && !dram_cas_n && !dram_oe_n && dram_we_n) begin
        if ((ras_t + 1) * CLK_NS >= RAC_NS && (cas_t + 1) * CLK_NS >= CAC_NS &&
            (a_t + 1) * CLK_NS >= AA_NS)
          dram_dq_in = mem_rd(m_row * 512 + m_col);
        else
          dram_dq_in = ~mem_rd(m_row * 512 + m_col);
      end
      if (rd_valid) begin
        n_rdv++;
        if (exp_q.size() == 0) chk(1'b0, "R10", "unexpected read data", 1, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(rd_data == e, "R3", "read data", int'(rd_data), int'(e));
        end
      end
      pr_ras = dram_ras_n;
      pr_cas = dram_cas_n;
      pr_we  = dram_we_n;
      pr_a   = dram_a;
    end
  end

  task automatic issue(input bit wr, input int addr, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = 19'(addr); req_wdata = d;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    if (wr) shadow[addr] = d;
    else begin
      exp_q.push_back(shadow.exists(addr) ? shadow[addr] : 8'h00);
      n_rd_issued++;
    end
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
    chk(exp_q.size() == 0, "R3", "reads outstanding", exp_q.size(), 0);
  endtask

  task automatic wait_ref();
    int r0;
    r0 = n_ref;
    for (int i = 0; i < T_REF + REF_SLACK + 20 && n_ref == r0; i++) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  function automatic int mk(input int row, input int col);
    return row * 512 + col;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R10", "watchdog expired", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int o0, r0;
    repeat (4) @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1", "strobes in reset", 0, 1);
    chk(!dram_dq_drive && !rd_valid, "R1", "drive/valid in reset", int'(dram_dq_drive), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R1", "ready after reset", int'(req_ready), 1);
    chk(dram_ras_n && dram_cas_n, "R1", "strobes after reset", int'(dram_ras_n), 1);

    // R2 R3 R4: row/column split, crossing addresses would collide if swapped
    issue(1, mk(5, 7), 8'hA1);
    issue(1, mk(7, 5), 8'hB2);
    issue(1, mk(1023, 511), 8'hC3);
    issue(1, mk(0, 0), 8'h5D);
    issue(0, mk(5, 7), 0);
    issue(0, mk(7, 5), 0);
    issue(0, mk(1023, 511), 0);
    issue(0, mk(0, 0), 0);
    issue(0, mk(9, 9), 0);
    drain();

    // R5: page hits need one row cycle
    wait_ref();
    o0 = n_open;
    issue(1, mk(20, 1), 8'h11);
    issue(0, mk(20, 1), 0);
    issue(1, mk(20, 2), 8'h22);
    issue(0, mk(20, 2), 0);
    drain();
    chk(n_open - o0 == 1, "R5", "row cycles for page burst", n_open - o0, 1);

    // R7: long hit run split by the row strobe limit
    wait_ref();
    o0 = n_open;
    for (int i = 0; i < 12; i++) issue(i % 2 == 0, mk(30, i), 8'(i * 3 + 1));
    for (int i = 0; i < 12; i++) issue(0, mk(30, i), 0);
    drain();
    chk(n_open - o0 >= 3, "R7", "row cycles for long run", n_open - o0, 3);

    // R6: alternating rows, each one a miss
    wait_ref();
    o0 = n_open;
    for (int i = 0; i < 6; i++) issue(0, mk(40 + i % 2, i), 0);
    drain();
    chk(n_open - o0 == 6, "R6", "row cycles for misses", n_open - o0, 6);

    // R8 R10: idle, only refreshes
    o0 = n_open;
    r0 = n_ref;
    repeat (3 * T_REF) @(negedge clk);
    chk(n_ref - r0 >= 2 && n_ref - r0 <= 4, "R8", "refreshes while idle", n_ref - r0, 3);
    chk(n_open == o0, "R10", "host row cycles while idle", n_open - o0, 0);

    // R9: continuous hits do not starve refresh
    r0 = n_ref;
    begin
      int c0;
      c0 = cyc;
      for (int i = 0; cyc - c0 < 2 * T_REF + 100; i++) issue(0, mk(50, i % 8), 0);
    end
    drain();
    chk(n_ref - r0 >= 2, "R9", "refreshes during hit stream", n_ref - r0, 2);
    chk(n_rdv == n_rd_issued, "R10", "read responses", n_rdv, n_rd_issued);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule